// File: doc/BRIEF.md
# Two-Lane Card Link Bring-Up and Dormant Tracker

This block follows, from the host side, the lane-level bring-up of a two-lane serial memory-card link. The transmit lane (D0) carries line states that the block selects. The receive lane (D1) is decoded elsewhere into one flag per line state. The block steps D0 through a fixed ordered handshake. D0 leaves electrical idle with a low standby symbol. After the device answers with the same symbol, D0 sends synchronization symbols. After the device echoes those, D0 sends logical idle. Once logical idle comes back, the link counts as synchronized.

A go-dormant strobe starts the power-down path. D0 sends a high standby symbol, waits for the device to echo it, and then drops to electrical idle. The dormant status is raised only after the receive lane has stayed in electrical idle for a programmable number of consecutive reference-clock cycles. While dormant, the clock enable may be lowered. Raising it again wakes the link and starts the handshake over.

The block reports three status bits: interface detected, lanes synchronized, and dormant. A test input can keep the synchronized bit low to model a failed physical-layer check that software then finds by timeout.

Top module: `lane_link_tracker`

## Requirements
- R1: After `rst`, and after any clock edge that samples `full_rst` high or `if_en` low, `d0_sym` is EIDL and all three status bits are 0. While `if_en` is 0, no input has any effect.
- R2: `d0_sym` uses a 3-bit code: 0 is electrical idle (EIDL), 1 is low standby (STB.L), 2 is high standby (STB.H), 3 is SYN and 4 is logical idle (LIDL).
- R3: With `if_en` high and the link idle, an edge that samples `clk_en` high makes `d0_sym` STB.L from the next cycle on.
- R4: While D0 sends STB.L, an edge that samples `rx_stbl` sets `st_detected` and moves D0 to SYN.
- R5: While D0 sends SYN, an edge that samples `rx_syn` moves D0 to LIDL. While D0 sends LIDL, an edge that samples `rx_lidl` sets `st_synced`, and D0 keeps sending LIDL.
- R6: Any edge that samples `rx_eidl` high clears `st_detected`. This clear wins over a set on the same edge.
- R7: `go_dormant` is accepted only after LIDL has been received, and it then moves D0 to STB.H. In any other phase the strobe is ignored. While D0 sends STB.H, `rx_stbh` moves D0 to EIDL.
- R8: `st_synced` clears on the edge where D0 returns to EIDL. It is never 1 while D0 sends EIDL.
- R9: In the dormant-entry EIDL phase, `st_dormant` sets on the DMT_CYCLES-th consecutive edge that samples `rx_eidl` high. A low sample before that point restarts the count.
- R10: While dormant, `clk_en` may be low without effect. An edge that samples `clk_en` high after it was sampled low on the previous edge clears `st_dormant` and makes D0 send STB.L.
- R11: While `phy_check_fail` is high, receiving LIDL does not set `st_synced`, although D0 still moves to the linked phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| if_en | input | 1 | Interface enable; low holds the block idle |
| clk_en | input | 1 | Link clock enable; starts bring-up and wakes the link from dormant |
| full_rst | input | 1 | Synchronous full reset of the link state |
| go_dormant | input | 1 | One-cycle strobe requesting dormant entry |
| phy_check_fail | input | 1 | Test input that keeps the synchronized bit low |
| rx_stbl | input | 1 | STB.L decoded on D1 |
| rx_stbh | input | 1 | STB.H decoded on D1 |
| rx_syn | input | 1 | SYN decoded on D1 |
| rx_lidl | input | 1 | LIDL decoded on D1 |
| rx_eidl | input | 1 | EIDL decoded on D1 |
| d0_sym | output | 3 | Line state selected for D0 (R2 code) |
| st_detected | output | 1 | Interface detected |
| st_synced | output | 1 | Lanes synchronized |
| st_dormant | output | 1 | Link is dormant |

## Verification
The bench builds the tracker with DMT_CYCLES set to 20 instead of 750. This makes it cheap to run the dormant delay to completion. It also brings within reach the case where the receive lane leaves idle one cycle short of the threshold, and the full count that follows. The other paths are exercised at this same value: a wake from dormant after the clock enable has been low, a standby symbol that arrives together with receive-lane idle, and the physical-check hook.

// File: rtl/lane_link_pkg.sv
package lane_link_pkg;

    // Line state selected for the transmit lane
    typedef enum logic [2:0] {
        D0_EIDL = 3'd0,
        D0_STBL = 3'd1,
        D0_STBH = 3'd2,
        D0_SYN  = 3'd3,
        D0_LIDL = 3'd4
    } d0_sym_e;

    // Bring-up / power-down phase
    typedef enum logic [2:0] {
        PH_OFF,
        PH_STBL,
        PH_SYN,
        PH_LIDL,
        PH_UP,
        PH_DSTBH,
        PH_DEIDL,
        PH_DORM
    } link_ph_e;

    // Decoded receive-lane flags
    typedef struct packed {
        logic stbl;
        logic stbh;
        logic syn;
        logic lidl;
        logic eidl;
    } rx_sym_t;

    typedef struct packed {
        logic detected;
        logic synced;
        logic dormant;
    } link_stat_t;

    function automatic d0_sym_e d0_for(link_ph_e ph);
        case (ph)
            PH_STBL:  return D0_STBL;
            PH_SYN:   return D0_SYN;
            PH_LIDL,
            PH_UP:    return D0_LIDL;
            PH_DSTBH: return D0_STBH;
            default:  return D0_EIDL;
        endcase
    endfunction

endpackage

// File: rtl/dormant_timer.sv
module dormant_timer #(
    parameter int THRESH = 750
) (
    input  logic clk,
    input  logic rst,
    input  logic kill,
    input  logic arm,
    input  logic eidl,
    output logic reach
);
    localparam int CNT_W = $clog2(THRESH + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(THRESH - 1);
    localparam logic [CNT_W-1:0] TOP  = CNT_W'(THRESH);

    logic [CNT_W-1:0] cnt_q;

    assign reach = arm && eidl && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (kill || !arm || !eidl) begin
            cnt_q <= '0;
        end else if (cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9: a low idle sample before the threshold restarts the count
    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (arm && !eidl) |=> (cnt_q == '0));

    // R9: consecutive idle samples advance the count by one
    assert_advance_R9: assert property (@(posedge clk) disable iff (rst)
        (!kill && arm && eidl && (cnt_q < LAST)) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/link_seq.sv
module link_seq
    import lane_link_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       kill,
    input  logic       clk_en,
    input  logic       clk_en_rise,
    input  logic       go_dormant,
    input  logic       phy_check_fail,
    input  rx_sym_t    rx,
    input  logic       dmt_reach,
    output link_ph_e   ph,
    output link_stat_t stat
);
    link_ph_e   ph_q, ph_d;
    link_stat_t st_q, st_d;

    always_comb begin
        ph_d = ph_q;
        st_d = st_q;
        case (ph_q)
            PH_OFF:   if (clk_en) ph_d = PH_STBL;
            PH_STBL:  if (rx.stbl) begin
                          ph_d = PH_SYN;
                          st_d.detected = 1'b1;
                      end
            PH_SYN:   if (rx.syn) ph_d = PH_LIDL;
            PH_LIDL:  if (rx.lidl) begin
                          ph_d = PH_UP;
                          if (!phy_check_fail) st_d.synced = 1'b1;
                      end
            PH_UP:    if (go_dormant) ph_d = PH_DSTBH;
            PH_DSTBH: if (rx.stbh) begin
                          ph_d = PH_DEIDL;
                          st_d.synced = 1'b0;
                      end
            PH_DEIDL: if (dmt_reach) begin
                          ph_d = PH_DORM;
                          st_d.dormant = 1'b1;
                      end
            PH_DORM:  if (clk_en_rise) begin
                          ph_d = PH_STBL;
                          st_d.dormant = 1'b0;
                      end
            default:  ph_d = PH_OFF;
        endcase
        if (rx.eidl) st_d.detected = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (kill) begin
            ph_q <= PH_OFF;
            st_q <= '0;
        end else begin
            ph_q <= ph_d;
            st_q <= st_d;
        end
    end

    assign ph   = ph_q;
    assign stat = st_q;

    // R4: standby answered while sending STB.L sets detection
    assert_detect_R4: assert property (@(posedge clk) disable iff (rst)
        (!kill && ph_q == PH_STBL && rx.stbl && !rx.eidl) |=> st_q.detected);

    // R6: receive-lane idle clears detection
    assert_eidl_clear_R6: assert property (@(posedge clk) disable iff (rst)
        rx.eidl |=> !st_q.detected);

    // R8: never synchronized while sending electrical idle
    assert_sync_not_idle_R8: assert property (@(posedge clk) disable iff (rst)
        st_q.synced |-> (d0_for(ph_q) != D0_EIDL));

    // R11: hook keeps the synchronized bit low
    assert_hook_R11: assert property (@(posedge clk) disable iff (rst)
        (phy_check_fail && !st_q.synced) |=> !st_q.synced);

    // R7: strobe before link-up does not start dormant entry
    assert_early_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        (go_dormant && ph_q inside {PH_OFF, PH_STBL, PH_SYN, PH_LIDL}) |=> (ph_q != PH_DSTBH));

endmodule

// File: rtl/lane_link_tracker.sv
module lane_link_tracker
    import lane_link_pkg::*;
#(
    parameter int DMT_CYCLES = 750
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       if_en,
    input  logic       clk_en,
    input  logic       full_rst,
    input  logic       go_dormant,
    input  logic       phy_check_fail,
    input  logic       rx_stbl,
    input  logic       rx_stbh,
    input  logic       rx_syn,
    input  logic       rx_lidl,
    input  logic       rx_eidl,
    output logic [2:0] d0_sym,
    output logic       st_detected,
    output logic       st_synced,
    output logic       st_dormant
);
    logic       kill;
    logic       clk_en_q;
    logic       clk_en_rise;
    logic       dmt_reach;
    rx_sym_t    rx;
    link_ph_e   ph;
    link_stat_t stat;

    assign kill        = rst || full_rst || !if_en;
    assign clk_en_rise = clk_en && !clk_en_q;
    assign rx          = '{stbl: rx_stbl, stbh: rx_stbh, syn: rx_syn,
                           lidl: rx_lidl, eidl: rx_eidl};

    always_ff @(posedge clk) begin
        if (rst) clk_en_q <= 1'b0;
        else     clk_en_q <= clk_en;
    end

    link_seq u_seq (
        .clk            (clk),
        .rst            (rst),
        .kill           (kill),
        .clk_en         (clk_en),
        .clk_en_rise    (clk_en_rise),
        .go_dormant     (go_dormant),
        .phy_check_fail (phy_check_fail),
        .rx             (rx),
        .dmt_reach      (dmt_reach),
        .ph             (ph),
        .stat           (stat)
    );

    dormant_timer #(.THRESH(DMT_CYCLES)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .kill  (kill),
        .arm   (ph == PH_DEIDL),
        .eidl  (rx_eidl),
        .reach (dmt_reach)
    );

    assign d0_sym      = 3'(d0_for(ph));
    assign st_detected = stat.detected;
    assign st_synced   = stat.synced;
    assign st_dormant  = stat.dormant;

    // R1: disable or full reset returns everything to idle
    assert_kill_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (full_rst || !if_en) |=> (d0_sym == 3'd0 && !st_detected && !st_synced && !st_dormant));

    // R9: dormant only rises after the timer reaches its threshold
    assert_dormant_timed_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(st_dormant) |-> $past(dmt_reach));

    // R10: clock-enable rising edge wakes the link
    assert_wake_R10: assert property (@(posedge clk) disable iff (rst)
        (st_dormant && clk_en && !clk_en_q && if_en && !full_rst) |=> (!st_dormant && d0_sym == 3'd1));

endmodule

// File: tb/sim_lane_link_tracker.sv
`timescale 1ns/1ps
module sim_lane_link_tracker;
    localparam int TH = 20;

    logic clk = 1'b0;
    logic rst = 1'b1, if_en = 1'b0, clk_en = 1'b0, full_rst = 1'b0, go_dormant = 1'b0;
    logic phy_check_fail = 1'b0;
    logic rx_stbl = 1'b0, rx_stbh = 1'b0, rx_syn = 1'b0, rx_lidl = 1'b0, rx_eidl = 1'b0;
    logic [2:0] d0_sym;
    logic st_detected, st_synced, st_dormant;

    always #2 clk = ~clk;

    lane_link_tracker #(.DMT_CYCLES(TH)) u0 (
        .clk(clk), .rst(rst), .if_en(if_en), .clk_en(clk_en), .full_rst(full_rst),
        .go_dormant(go_dormant), .phy_check_fail(phy_check_fail),
        .rx_stbl(rx_stbl), .rx_stbh(rx_stbh), .rx_syn(rx_syn), .rx_lidl(rx_lidl),
        .rx_eidl(rx_eidl), .d0_sym(d0_sym), .st_detected(st_detected),
        .st_synced(st_synced), .st_dormant(st_dormant)
    );

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R1";

    // Behavioural reference: step 0 idle, 1 standby-low, 2 sync, 3 logical idle,
    // 4 linked, 5 standby-high, 6 idle wait, 7 dormant
    int m_step = 0, m_det = 0, m_syn = 0, m_dorm = 0, m_run = 0, m_prev_ce = 0;
    bit started = 0;
    int code_of[8] = '{0, 1, 3, 4, 4, 2, 0, 0};

    always @(posedge clk) begin
        started = 1;
        if (rst || full_rst || !if_en) begin
            m_step = 0; m_det = 0; m_syn = 0; m_dorm = 0; m_run = 0;
        end else begin
            case (m_step)
                0: if (clk_en) m_step = 1;
                1: if (rx_stbl) begin m_det = 1; m_step = 2; end
                2: if (rx_syn) m_step = 3;
                3: if (rx_lidl) begin if (!phy_check_fail) m_syn = 1; m_step = 4; end
                4: if (go_dormant) m_step = 5;
                5: if (rx_stbh) begin m_syn = 0; m_step = 6; end
                6: begin
                    if (rx_eidl) m_run++; else m_run = 0;
                    if (m_run == TH) begin m_dorm = 1; m_step = 7; m_run = 0; end
                end
                7: if (clk_en && !m_prev_ce) begin m_dorm = 0; m_step = 1; end
                default: m_step = 0;
            endcase
            if (m_step != 6) m_run = 0;
            if (rx_eidl) m_det = 0;
        end
        m_prev_ce = rst ? 0 : int'(clk_en);
    end

    task automatic cmp(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            cmp("d0_sym", int'(d0_sym), code_of[m_step]);
            cmp("detected", int'(st_detected), m_det);
            cmp("synced", int'(st_synced), m_syn);
            cmp("dormant", int'(st_dormant), m_dorm);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        cur_req = "R1";                       // disabled: inputs ignored
        clk_en = 1'b1; rx_stbl = 1'b1; rx_syn = 1'b1; go_dormant = 1'b1;
        step(3);
        rx_stbl = 1'b0; rx_syn = 1'b0; go_dormant = 1'b0;
        cur_req = "R3"; if_en = 1'b1; step(2);
        cur_req = "R2"; cmp("STB.L code", int'(d0_sym), 1); step(1);
        cur_req = "R7"; go_dormant = 1'b1; step(1); go_dormant = 1'b0; step(2);
        cur_req = "R4"; rx_stbl = 1'b1; step(1); rx_stbl = 1'b0; step(2);
        cur_req = "R6"; rx_eidl = 1'b1; step(1); rx_eidl = 1'b0; step(1);
        cur_req = "R5"; rx_syn = 1'b1; step(1); rx_syn = 1'b0; step(2);
        rx_lidl = 1'b1; step(1); rx_lidl = 1'b0; step(2);
        cur_req = "R7"; go_dormant = 1'b1; step(1); go_dormant = 1'b0; step(2);
        cur_req = "R8"; rx_stbh = 1'b1; step(1); rx_stbh = 1'b0; step(2);
        cur_req = "R9"; rx_eidl = 1'b1; step(TH - 1); rx_eidl = 1'b0; step(2);
        rx_eidl = 1'b1; step(TH + 4);
        rx_eidl = 1'b0;
        cur_req = "R10"; clk_en = 1'b0; step(4); clk_en = 1'b1; step(2);
        cur_req = "R6"; rx_stbl = 1'b1; rx_eidl = 1'b1; step(1);
        rx_stbl = 1'b0; rx_eidl = 1'b0; step(1);
        cur_req = "R11"; phy_check_fail = 1'b1;
        rx_syn = 1'b1; step(1); rx_syn = 1'b0; step(1);
        rx_lidl = 1'b1; step(1); rx_lidl = 1'b0; step(3);
        phy_check_fail = 1'b0;
        cur_req = "R1"; full_rst = 1'b1; step(1); full_rst = 1'b0; step(2);
        if_en = 1'b0; step(2); if_en = 1'b1; step(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL %s watchdog: actual 1 expected 0", cur_req);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule